// File: doc/BRIEF.md
# Single-Bit Boolean Processor

This block carries out single-bit operations on a byte-organised internal data space that has 256 directly addressable bits. A request carries an 8-bit bit address and a 4-bit operation code. The block turns the bit address into the address of the byte that holds the bit and into a bit index. It then reads that byte over a synchronous memory port. Depending on the operation, it either reports the selected bit or writes the byte back with only that bit changed. A one-bit carry register acts as the boolean accumulator for the logical operations.

The lower half of the bit space maps onto a 16-byte RAM window. The upper half maps onto the registers whose byte addresses are multiples of eight. The carry flag also exists in that map, as bit 7 of the status byte at 0xD0, which is bit address 0xD7. Operations that target that bit update the carry register and the stored status byte together. The surrounding core fetches instructions, decodes branches and holds the storage. It issues one request at a time and waits for the done strobe.

Top module: `bitproc_unit`

## Requirements
- R1: Reset, which is synchronous and active high, leaves `busy`, `done`, `mem_rd`, `mem_wr`, `carry_out` and `cond_out` all at 0.
- R2: A bit address below 0x80 reads byte 0x20 + bits 6:3 of the address. The bit index is bits 2:0, so 0x05 selects byte 0x20 bit 5 and 0x7F selects byte 0x2F bit 7.
- R3: A bit address of 0x80 or above reads the byte whose address is the bit address with bits 2:0 cleared, with bits 2:0 as the bit index. For example, 0x93 selects byte 0x90 bit 3.
- R4: Codes 0 (clear), 1 (set), 2 (invert) and 4 (store carry into the bit) write the containing byte back. Only the indexed bit takes the new value, and the other seven bits keep the value that was read.
- R5: Code 3 loads the bit into carry. Codes 5 (carry AND bit), 6 (carry OR bit), 7 (carry AND NOT bit) and 8 (carry OR NOT bit) update carry from the bit. None of these codes writes memory unless the target is 0xD7.
- R6: Every operation returns the bit value as it was read on `cond_out`, valid while `done` is high and held until the next completion. Code 9 (test) changes neither memory nor carry.
- R7: After any write code or carry code whose target is bit address 0xD7, the carry register and bit 7 of stored byte 0xD0 hold the same value. The write codes also set carry, and the carry codes also write the byte back.
- R8: A request sampled at clock edge N gives exactly one memory read. `done` pulses for one cycle after edge N+2 when no write is needed, or after edge N+3 when one write is issued.
- R9: A request presented while `busy` is high is ignored and causes no memory access.
- R10: The unused codes 10 to 15 act as the test operation: no write and no change to carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe, sampled only while idle |
| req_op | input | 4 | Operation code |
| req_bit | input | 8 | Bit address |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion strobe |
| cond_out | output | 1 | Bit value read by the last operation |
| carry_out | output | 1 | Carry register |
| mem_rd | output | 1 | Byte read strobe; data is returned on the next cycle |
| mem_wr | output | 1 | Byte write strobe |
| mem_addr | output | 8 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, registered by the storage |

## Verification
The bench builds the block with its default parameters: an 8-bit bit address, 8-bit bytes, a RAM window at 0x20 and the carry at 0xD7. With these values the corners of both halves of the map can be reached, including 0x00, 0x7F, 0x80 and 0xFF, as well as the status byte that holds the carry. A byte-wide model of storage preset with a non-trivial pattern makes every stray write to a neighbouring bit or byte visible. A request issued in the middle of an operation shows whether the busy lockout holds.

// File: rtl/bitproc_pkg.sv
package bitproc_pkg;

  typedef enum logic [3:0] {
    OP_CLR  = 4'd0,
    OP_SET  = 4'd1,
    OP_INV  = 4'd2,
    OP_LDC  = 4'd3,
    OP_STC  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_ANDN = 4'd7,
    OP_ORN  = 4'd8,
    OP_TEST = 4'd9
  } bp_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_EXEC,
    ST_WRITE
  } bp_state_e;

endpackage

// File: rtl/bitproc_bitmap.sv
module bitproc_bitmap #(
  parameter int BIT_AW       = 8,
  parameter int DATA_W       = 8,
  parameter int RAM_WIN_BASE = 'h20
) (
  input  logic [BIT_AW-1:0]         bit_addr,
  output logic [BIT_AW-1:0]         byte_addr,
  output logic [$clog2(DATA_W)-1:0] bit_idx
);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [BIT_AW-1:0] BASE = BIT_AW'(RAM_WIN_BASE);

  logic [BIT_AW-1:0] low_byte;
  logic [BIT_AW-1:0] high_byte;

  always_comb begin
    low_byte  = BASE + BIT_AW'(bit_addr[BIT_AW-2:IDX_W]);
    high_byte = {bit_addr[BIT_AW-1:IDX_W], {IDX_W{1'b0}}};
    byte_addr = bit_addr[BIT_AW-1] ? high_byte : low_byte;
    bit_idx   = bit_addr[IDX_W-1:0];
  end
endmodule

// File: rtl/bitproc_alu.sv
module bitproc_alu
  import bitproc_pkg::*;
(
  input  logic [3:0] op,
  input  logic       bit_in,
  input  logic       cy_in,
  output logic       bit_out,
  output logic       bit_wr,
  output logic       cy_out,
  output logic       cy_op
);
  always_comb begin
    bit_out = bit_in;
    bit_wr  = 1'b0;
    cy_out  = cy_in;
    cy_op   = 1'b0;
    case (op)
      OP_CLR:  begin bit_out = 1'b0;    bit_wr = 1'b1; end
      OP_SET:  begin bit_out = 1'b1;    bit_wr = 1'b1; end
      OP_INV:  begin bit_out = ~bit_in; bit_wr = 1'b1; end
      OP_STC:  begin bit_out = cy_in;   bit_wr = 1'b1; end
      OP_LDC:  begin cy_out = bit_in;           cy_op = 1'b1; end
      OP_AND:  begin cy_out = cy_in & bit_in;   cy_op = 1'b1; end
      OP_OR:   begin cy_out = cy_in | bit_in;   cy_op = 1'b1; end
      OP_ANDN: begin cy_out = cy_in & ~bit_in;  cy_op = 1'b1; end
      OP_ORN:  begin cy_out = cy_in | ~bit_in;  cy_op = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/bitproc_unit.sv
module bitproc_unit
  import bitproc_pkg::*;
#(
  parameter int BIT_AW       = 8,
  parameter int DATA_W       = 8,
  parameter int RAM_WIN_BASE = 'h20,
  parameter int CARRY_BIT    = 'hD7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [3:0]        req_op,
  input  logic [BIT_AW-1:0] req_bit,
  output logic              busy,
  output logic              done,
  output logic              cond_out,
  output logic              carry_out,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [BIT_AW-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [BIT_AW-1:0] CY_ADDR = BIT_AW'(CARRY_BIT);

  bp_state_e         state;
  logic [3:0]        op_q;
  logic [IDX_W-1:0]  idx_q;
  logic              tgt_cy_q;

  logic [BIT_AW-1:0] map_byte;
  logic [IDX_W-1:0]  map_idx;

  logic              bit_val;
  logic              alu_bit;
  logic              alu_bit_wr;
  logic              alu_cy;
  logic              alu_cy_op;
  logic              need_wr;
  logic              wr_bit;
  logic              cy_next;
  logic [DATA_W-1:0] merged;

  bitproc_bitmap #(
    .BIT_AW(BIT_AW), .DATA_W(DATA_W), .RAM_WIN_BASE(RAM_WIN_BASE)
  ) u_map (
    .bit_addr (req_bit),
    .byte_addr(map_byte),
    .bit_idx  (map_idx)
  );

  assign bit_val = mem_rdata[idx_q];

  bitproc_alu u_alu (
    .op    (op_q),
    .bit_in(bit_val),
    .cy_in (carry_out),
    .bit_out(alu_bit),
    .bit_wr(alu_bit_wr),
    .cy_out(alu_cy),
    .cy_op (alu_cy_op)
  );

  // Carry coherence: a write into the carry bit also loads the carry
  // register; a carry update aimed at the carry bit is written back.
  always_comb begin
    need_wr = alu_bit_wr | (tgt_cy_q & alu_cy_op);
    wr_bit  = alu_bit_wr ? alu_bit : alu_cy;
    cy_next = (tgt_cy_q & alu_bit_wr) ? alu_bit : alu_cy;
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_merge
    assign merged[i] = (idx_q == IDX_W'(i)) ? wr_bit : mem_rdata[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      op_q      <= '0;
      idx_q     <= '0;
      tgt_cy_q  <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      cond_out  <= 1'b0;
      carry_out <= 1'b0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            op_q     <= req_op;
            idx_q    <= map_idx;
            tgt_cy_q <= (req_bit == CY_ADDR);
            mem_addr <= map_byte;
            mem_rd   <= 1'b1;
            busy     <= 1'b1;
            state    <= ST_READ;
          end
        end
        ST_READ: begin
          mem_rd <= 1'b0;
          state  <= ST_EXEC;
        end
        ST_EXEC: begin
          cond_out  <= bit_val;
          carry_out <= cy_next;
          if (need_wr) begin
            mem_wr    <= 1'b1;
            mem_wdata <= merged;
            state     <= ST_WRITE;
          end else begin
            done  <= 1'b1;
            busy  <= 1'b0;
            state <= ST_IDLE;
          end
        end
        default: begin
          mem_wr <= 1'b0;
          done   <= 1'b1;
          busy   <= 1'b0;
          state  <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/bitproc_unit_chk.sv
module bitproc_unit_chk #(
  parameter int BIT_AW       = 8,
  parameter int DATA_W       = 8,
  parameter int RAM_WIN_BASE = 'h20
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [BIT_AW-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [DATA_W-1:0] mem_rdata
);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [BIT_AW-1:0] BASE = BIT_AW'(RAM_WIN_BASE);
  localparam logic [BIT_AW-1:0] TOP  = BASE + BIT_AW'((1 << (BIT_AW-1-IDX_W)) - 1);

  assert_map_R2: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> ((mem_addr >= BASE && mem_addr <= TOP) ||
                (mem_addr[BIT_AW-1] && mem_addr[IDX_W-1:0] == '0)));

  assert_wr_follows_rd_R4: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> ($past(mem_rd, 2) && mem_addr == $past(mem_addr, 2)));

  assert_single_bit_R4: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> ($countones(mem_wdata ^ $past(mem_rdata)) <= 1));

  assert_one_read_R8: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_rw_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  assert_accept_idle_R9: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> (busy && !$past(busy)));
endmodule

bind bitproc_unit bitproc_unit_chk #(
  .BIT_AW(BIT_AW), .DATA_W(DATA_W), .RAM_WIN_BASE(RAM_WIN_BASE)
) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .mem_rd(mem_rd),
  .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_rdata(mem_rdata)
);

// File: tb/bitproc_unit_tb.sv
module bitproc_unit_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [3:0] req_op = '0;
  logic [7:0] req_bit = '0;
  logic       busy, done, cond_out, carry_out, mem_rd, mem_wr;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;

  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  logic       model_cy;
  int rd_cnt, wr_cnt, n_chk, n_bad;
  logic [7:0] last_rd_addr;
  bit finished;

  always #2.5 clk = ~clk;

  bitproc_unit u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_bit(req_bit), .busy(busy), .done(done), .cond_out(cond_out),
    .carry_out(carry_out), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] pat(int i);
    return 8'(i * 37 + 11);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= pat(i);
      mem_rdata <= '0;
      rd_cnt <= 0;
      wr_cnt <= 0;
      last_rd_addr <= '0;
    end else begin
      if (mem_wr) begin
        mem[mem_addr] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end
      if (mem_rd) begin
        mem_rdata <= mem[mem_addr];
        rd_cnt <= rd_cnt + 1;
        last_rd_addr <= mem_addr;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [7:0] byte_of(logic [7:0] b);
    return b[7] ? {b[7:3], 3'b000} : 8'h20 + {4'h0, b[6:3]};
  endfunction

  task automatic run_op(input logic [3:0] op, input logic [7:0] b,
                        input bit intrude, input string req);
    logic [7:0] byt;
    logic [2:0] idx;
    logic ob, ecy, wbit;
    bit wr;
    int rd0, wr0, n, mism;
    byt = byte_of(b);
    idx = b[2:0];
    ob = exp_mem[byt][idx];
    ecy = model_cy;
    wr = 0;
    wbit = 1'b0;
    case (op)
      4'd0: begin wr = 1; wbit = 1'b0; end
      4'd1: begin wr = 1; wbit = 1'b1; end
      4'd2: begin wr = 1; wbit = ~ob; end
      4'd4: begin wr = 1; wbit = model_cy; end
      4'd3: ecy = ob;
      4'd5: ecy = model_cy & ob;
      4'd6: ecy = model_cy | ob;
      4'd7: ecy = model_cy & ~ob;
      4'd8: ecy = model_cy | ~ob;
      default: ;
    endcase
    if (b == 8'hD7) begin
      if (wr) ecy = wbit;
      else if (op >= 4'd3 && op <= 4'd8) begin wr = 1; wbit = ecy; end
    end
    if (wr) exp_mem[byt][idx] = wbit;
    model_cy = ecy;
    rd0 = rd_cnt;
    wr0 = wr_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_bit = b;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (intrude) begin
      req_valid = 1'b1; req_op = 4'd1; req_bit = 8'h01;
    end
    n = 0;
    while (n < 10) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      req_valid = 1'b0;
      if (done) break;
    end
    chk(n == (wr ? 3 : 2), req, "done latency", n, wr ? 3 : 2);
    chk(cond_out == ob, "R6", "cond_out", cond_out, ob);
    chk(carry_out == ecy, req, "carry", carry_out, ecy);
    chk(last_rd_addr == byt, b[7] ? "R3" : "R2", "byte addr", last_rd_addr, byt);
    repeat (3) @(negedge clk);
    chk(rd_cnt - rd0 == 1, "R8", "read count", rd_cnt - rd0, 1);
    chk(wr_cnt - wr0 == int'(wr), req, "write count", wr_cnt - wr0, int'(wr));
    mism = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) mism++;
    chk(mism == 0, req, "memory image mismatches", mism, 0);
  endtask

  task automatic t_reset;
    chk(!busy && !done && !mem_rd && !mem_wr, "R1", "control outputs",
        {busy, done, mem_rd, mem_wr}, 0);
    chk(carry_out == 0 && cond_out == 0, "R1", "carry/cond", {carry_out, cond_out}, 0);
  endtask

  task automatic t_low_map;
    run_op(4'd1, 8'h05, 0, "R2");
    run_op(4'd0, 8'h7F, 0, "R2");
    run_op(4'd2, 8'h00, 0, "R4");
  endtask

  task automatic t_high_map;
    run_op(4'd0, 8'h93, 0, "R3");
    run_op(4'd2, 8'hF8, 0, "R3");
    run_op(4'd1, 8'hFF, 0, "R3");
    run_op(4'd2, 8'h80, 0, "R4");
  endtask

  task automatic t_carry_ops;
    run_op(4'd1, 8'h10, 0, "R4");
    run_op(4'd3, 8'h10, 0, "R5");
    run_op(4'd4, 8'hA2, 0, "R4");
    run_op(4'd5, 8'h7F, 0, "R5");
    run_op(4'd6, 8'h05, 0, "R5");
    run_op(4'd7, 8'h05, 0, "R5");
    run_op(4'd8, 8'h7F, 0, "R5");
    run_op(4'd9, 8'h93, 0, "R6");
  endtask

  task automatic t_carry_coherence;
    run_op(4'd1, 8'hD7, 0, "R7");
    chk(exp_mem[8'hD0][7] == carry_out, "R7", "status vs carry", carry_out, exp_mem[8'hD0][7]);
    run_op(4'd5, 8'h7F, 0, "R5");
    run_op(4'd6, 8'hD7, 0, "R7");
    run_op(4'd0, 8'hD7, 0, "R7");
    run_op(4'd8, 8'hD7, 0, "R7");
    chk(mem[8'hD0][7] == carry_out, "R7", "stored status bit vs carry", mem[8'hD0][7], carry_out);
    run_op(4'd4, 8'hD3, 0, "R4");
    run_op(4'd2, 8'hD4, 0, "R4");
  endtask

  task automatic t_busy;
    run_op(4'd0, 8'h30, 1, "R9");
  endtask

  task automatic t_undef;
    run_op(4'd10, 8'h05, 0, "R10");
    run_op(4'd15, 8'hD7, 0, "R10");
  endtask

  initial begin
    model_cy = 1'b0;
    n_chk = 0;
    n_bad = 0;
    for (int i = 0; i < 256; i++) exp_mem[i] = pat(i);
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset;
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_low_map;
    t_high_map;
    t_carry_ops;
    t_carry_coherence;
    t_busy;
    t_undef;
    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule